// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Nibble Carry

This block is the purely combinational datapath core of a small accumulator-style controller. It combines the working value `w_in` with a second operand. That operand is either the value fetched from the register file or an 8-bit literal from the instruction word. The block returns the 8-bit result in the same evaluation, with no clock involved.

For the three status bits it returns proposed next values. Alongside them it returns a per-bit write-enable mask, so the surrounding status register only changes the flags the selected operation is defined to touch. A separate skip indication tells the sequencer to discard the next instruction word. The skip is raised by the counting-skip and bit-test operations.

Status positions are fixed throughout: carry is bit 0, half-carry is bit 1 and zero is bit 2 of both `flag_next` and `flag_we`. The operation is chosen by a 5-bit code on `op_sel`. Codes 18 to 31 are unassigned.

Top module: `alu8_core`

## Requirements
- R1: Code 0 (add) gives result = (B + W) mod 256. It proposes carry = carry out of bit 7, half-carry = carry out of bit 3 and zero = (result == 0), and it enables all three flags (flag_we = 3'b111).
- R2: Code 1 (subtract) gives result = B + ~W + 1 = (B − W) mod 256. Carry = 1 exactly when B ≥ W, which means no borrow. Half-carry = 1 exactly when B[3:0] ≥ W[3:0]. Zero follows the result, and all three flags are enabled.
- R3: Code 2 (increment) gives B + 1 and code 3 (decrement) gives B − 1, both modulo 256. Each enables only the zero flag (flag_we = 3'b100).
- R4: Code 6 (B AND W), code 7 (B OR W), code 8 (B XOR W), code 9 (bitwise complement of B) and code 13 (clear, result 0) enable only the zero flag, which is 1 when the result is 0.
- R5: Code 10 exchanges the upper and lower four bits of B. It enables no flag and raises no skip.
- R6: Code 11 rotates right through carry: carry_in enters bit 7 and B[0] becomes the proposed carry. Code 12 rotates left through carry: carry_in enters bit 0 and B[7] becomes the proposed carry. Both enable only the carry flag (flag_we = 3'b001).
- R7: Code 4 (increment, skip if zero) and code 5 (decrement, skip if zero) give B + 1 and B − 1 respectively. They raise skip exactly when the result is 0 and enable no flag.
- R8: Code 14 sets and code 15 clears bit bit_sel of B. All other bits pass through unchanged, and no flag is enabled.
- R9: Code 16 raises skip when B[bit_sel] is 0, and code 17 raises skip when B[bit_sel] is 1. The result equals B, and no flag is enabled.
- R10: In flag_next and flag_we, carry is bit 0, half-carry is bit 1 and zero is bit 2.
- R11: B is imm_in when use_imm is 1 and reg_in when use_imm is 0.
- R12: Codes 18 to 31 give result = B, enable no flag and raise no skip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| w_in | input | 8 | Working value W |
| reg_in | input | 8 | Register-file operand |
| imm_in | input | 8 | Literal operand from the instruction |
| use_imm | input | 1 | Selects imm_in as operand B |
| op_sel | input | 5 | Operation code |
| carry_in | input | 1 | Present carry flag |
| bit_sel | input | 3 | Bit index for the bit operations |
| result | output | 8 | Operation result |
| flag_next | output | 3 | Proposed {zero, half-carry, carry} |
| flag_we | output | 3 | Per-flag write enable, same positions |
| skip | output | 1 | Discard the next instruction |

## Verification
The block holds no state, so any internal fault shows at the ports in the same evaluation as the stimulus that exposes it. No later cycle is needed. A broken nibble carry chain shows as a wrong half-carry or a wrong upper nibble on operands that carry across bit 3. A wrong decode of the enable mask shows as an extra or missing `flag_we` bit for that one operation code. The directed vectors therefore sit on the carry and borrow boundaries at bits 3 and 7, on every bit index, and on results of zero.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 5;
    localparam int FLG_N  = 3;
    localparam int FLG_C  = 0;
    localparam int FLG_H  = 1;
    localparam int FLG_Z  = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_INC   = 5'd2,
        OP_DEC   = 5'd3,
        OP_INCSZ = 5'd4,
        OP_DECSZ = 5'd5,
        OP_AND   = 5'd6,
        OP_OR    = 5'd7,
        OP_XOR   = 5'd8,
        OP_COM   = 5'd9,
        OP_SWAP  = 5'd10,
        OP_RRC   = 5'd11,
        OP_RLC   = 5'd12,
        OP_CLR   = 5'd13,
        OP_BSET  = 5'd14,
        OP_BCLR  = 5'd15,
        OP_BTSC  = 5'd16,
        OP_BTSS  = 5'd17
    } alu_op_e;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              c_nib,
    output logic              c_top
);
    localparam int NIBS = DATA_W / NIB_W;

    logic [NIBS:0] cy;
    assign cy[0] = cin;

    // ripple of nibble-wide adders; the first inter-nibble carry is the half-carry
    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        assign {cy[g+1], sum[g*NIB_W +: NIB_W]} =
            {1'b0, a_in[g*NIB_W +: NIB_W]} + {1'b0, b_in[g*NIB_W +: NIB_W]}
            + (NIB_W+1)'(cy[g]);
    end

    assign c_nib = cy[1];
    assign c_top = cy[NIBS];

    always_comb begin
        AST_ADD_WIDE: assert ({c_top, sum} ==
            (DATA_W+1)'(a_in) + (DATA_W+1)'(b_in) + (DATA_W+1)'(cin))
            else $error("nibble chain disagrees with full-width sum"); // R1
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] opnd,
    input  logic [DATA_W-1:0] w_val,
    input  logic              carry_in,
    input  logic [SEL_W-1:0]  bit_sel,
    output logic [DATA_W-1:0] res,
    output logic              rot_carry,
    output logic              test_bit
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] sel_mask;
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign sel_mask[g] = (bit_sel == SEL_W'(g));
    end

    assign test_bit = |(opnd & sel_mask);

    always_comb begin
        res       = opnd;
        rot_carry = carry_in;
        unique case (op)
            OP_AND:  res = opnd & w_val;
            OP_OR:   res = opnd | w_val;
            OP_XOR:  res = opnd ^ w_val;
            OP_COM:  res = ~opnd;
            OP_SWAP: res = {opnd[HALF-1:0], opnd[DATA_W-1:HALF]};
            OP_RRC: begin
                res       = {carry_in, opnd[DATA_W-1:1]};
                rot_carry = opnd[0];
            end
            OP_RLC: begin
                res       = {opnd[DATA_W-2:0], carry_in};
                rot_carry = opnd[DATA_W-1];
            end
            OP_CLR:  res = '0;
            OP_BSET: res = opnd | sel_mask;
            OP_BCLR: res = opnd & ~sel_mask;
            default: res = opnd;
        endcase
    end
endmodule

// File: rtl/alu8_flagctl.sv
module alu8_flagctl
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] res,
    input  logic              add_c_top,
    input  logic              add_c_nib,
    input  logic              rot_carry,
    input  logic              test_bit,
    output logic [FLG_N-1:0]  flag_next,
    output logic [FLG_N-1:0]  flag_we,
    output logic              skip
);
    logic is_rot;
    logic res_zero;

    assign is_rot   = (op == OP_RRC) || (op == OP_RLC);
    assign res_zero = ~|res;

    always_comb begin
        flag_next        = '0;
        flag_next[FLG_C] = is_rot ? rot_carry : add_c_top;
        flag_next[FLG_H] = add_c_nib;
        flag_next[FLG_Z] = res_zero;
    end

    always_comb begin
        flag_we = '0;
        unique case (op)
            OP_ADD, OP_SUB:  flag_we = '1;
            OP_INC, OP_DEC, OP_AND, OP_OR,
            OP_XOR, OP_COM, OP_CLR: flag_we[FLG_Z] = 1'b1;
            OP_RRC, OP_RLC:  flag_we[FLG_C] = 1'b1;
            default:         flag_we = '0;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_INCSZ, OP_DECSZ: skip = res_zero;
            OP_BTSC:            skip = ~test_bit;
            OP_BTSS:            skip = test_bit;
            default:            skip = 1'b0;
        endcase
    end

    always_comb begin
        AST_SKIP_NO_FLAGS: assert (!skip || flag_we == '0)
            else $error("skip raised together with a flag write"); // R7
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [7:0] w_in,
    input  logic [7:0] reg_in,
    input  logic [7:0] imm_in,
    input  logic       use_imm,
    input  logic [4:0] op_sel,
    input  logic       carry_in,
    input  logic [2:0] bit_sel,
    output logic [7:0] result,
    output logic [2:0] flag_next,
    output logic [2:0] flag_we,
    output logic       skip
);
    localparam int SEL_W = $clog2(DATA_W);

    alu_op_e           op;
    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] add_a, add_b, add_sum, bit_res;
    logic              add_cin, add_c_nib, add_c_top;
    logic              rot_carry, test_bit;
    logic              is_arith;

    assign op   = alu_op_e'(op_sel);
    assign opnd = use_imm ? imm_in : reg_in;

    // adder operand steering: subtract and decrement use inverted or all-ones addends
    always_comb begin
        add_a    = opnd;
        add_b    = '0;
        add_cin  = 1'b0;
        is_arith = 1'b1;
        unique case (op)
            OP_ADD:             add_b = w_in;
            OP_SUB: begin
                add_b   = ~w_in;
                add_cin = 1'b1;
            end
            OP_INC, OP_INCSZ:   add_cin = 1'b1;
            OP_DEC, OP_DECSZ:   add_b = '1;
            default:            is_arith = 1'b0;
        endcase
    end

    alu8_adder #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_adder (
        .a_in  (add_a),
        .b_in  (add_b),
        .cin   (add_cin),
        .sum   (add_sum),
        .c_nib (add_c_nib),
        .c_top (add_c_top)
    );

    alu8_bitops #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_bitops (
        .op        (op),
        .opnd      (opnd),
        .w_val     (w_in),
        .carry_in  (carry_in),
        .bit_sel   (bit_sel),
        .res       (bit_res),
        .rot_carry (rot_carry),
        .test_bit  (test_bit)
    );

    assign result = is_arith ? add_sum : bit_res;

    alu8_flagctl #(.DATA_W(DATA_W)) u_flagctl (
        .op        (op),
        .res       (result),
        .add_c_top (add_c_top),
        .add_c_nib (add_c_nib),
        .rot_carry (rot_carry),
        .test_bit  (test_bit),
        .flag_next (flag_next),
        .flag_we   (flag_we),
        .skip      (skip)
    );

    always_comb begin
        if (op == OP_RRC || op == OP_RLC) begin
            AST_ROT_ONES: assert ($countones({flag_next[FLG_C], result}) ==
                                  $countones({carry_in, opnd}))
                else $error("rotate lost or created a bit"); // R6
        end
        if (op == OP_SWAP) begin
            AST_SWAP_ONES: assert ($countones(result) == $countones(opnd))
                else $error("swap changed the bit count"); // R5
        end
        if (op == OP_BSET || op == OP_BCLR) begin
            AST_BIT_ONEHOT: assert ($onehot0(result ^ opnd))
                else $error("bit operation changed more than one bit"); // R8
        end
    end
endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
    localparam logic [4:0] C_ADD = 5'd0,  C_SUB = 5'd1,  C_INC = 5'd2,  C_DEC = 5'd3;
    localparam logic [4:0] C_INCSZ = 5'd4, C_DECSZ = 5'd5, C_AND = 5'd6, C_OR = 5'd7;
    localparam logic [4:0] C_XOR = 5'd8,  C_COM = 5'd9,  C_SWAP = 5'd10, C_RRC = 5'd11;
    localparam logic [4:0] C_RLC = 5'd12, C_CLR = 5'd13, C_BSET = 5'd14, C_BCLR = 5'd15;
    localparam logic [4:0] C_BTSC = 5'd16, C_BTSS = 5'd17;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] w_in = '0, reg_in = '0, imm_in = '0;
    logic       use_imm = 1'b0, carry_in = 1'b0;
    logic [4:0] op_sel = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] result;
    logic [2:0] flag_next, flag_we;
    logic       skip;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    alu8_core u_alu8_core (
        .w_in(w_in), .reg_in(reg_in), .imm_in(imm_in), .use_imm(use_imm),
        .op_sel(op_sel), .carry_in(carry_in), .bit_sel(bit_sel),
        .result(result), .flag_next(flag_next), .flag_we(flag_we), .skip(skip)
    );

    task automatic drive(input logic [4:0] op, input logic [7:0] w, input logic [7:0] r,
                         input logic [7:0] imm, input logic ui, input logic ci,
                         input logic [2:0] b);
        @(negedge clk);
        op_sel = op; w_in = w; reg_in = r; imm_in = imm;
        use_imm = ui; carry_in = ci; bit_sel = b;
        #2;
    endtask

    task automatic cmp(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // flags given as {z,h,c}; only enabled positions are compared
    task automatic expect_all(input string tag, input logic [7:0] er, input logic [2:0] ef,
                              input logic [2:0] ew, input logic es);
        cmp(tag, "result", int'(result), int'(er));
        cmp(tag, "flag_we", int'(flag_we), int'(ew));
        cmp(tag, "flag_next", int'(flag_next & ew), int'(ef & ew));
        cmp(tag, "skip", int'(skip), int'(es));
    endtask

    task automatic t_reset();
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #2;
        expect_all("R1 reset", 8'h00, 3'b100, 3'b111, 1'b0);
    endtask

    task automatic t_add();
        logic [7:0] wv [4] = '{8'h0F, 8'hFF, 8'h80, 8'h12};
        logic [7:0] rv [4] = '{8'h01, 8'h01, 8'h80, 8'h34};
        for (int i = 0; i < 4; i++) begin
            int s = int'(rv[i]) + int'(wv[i]);
            logic c = s > 255;
            logic h = (int'(rv[i] & 8'h0F) + int'(wv[i] & 8'h0F)) > 15;
            logic z = (s % 256) == 0;
            drive(C_ADD, wv[i], rv[i], 8'h00, 1'b0, 1'b0, 3'd0);
            expect_all("R1 R10 add", 8'(s), {z, h, c}, 3'b111, 1'b0);
        end
    endtask

    task automatic t_sub();
        logic [7:0] rv [4] = '{8'h05, 8'h03, 8'h10, 8'h40};
        logic [7:0] wv [4] = '{8'h03, 8'h05, 8'h01, 8'h40};
        for (int i = 0; i < 4; i++) begin
            int d = int'(rv[i]) - int'(wv[i]);
            logic c = rv[i] >= wv[i];
            logic h = (rv[i] & 8'h0F) >= (wv[i] & 8'h0F);
            logic z = d == 0;
            drive(C_SUB, wv[i], rv[i], 8'h00, 1'b0, 1'b1, 3'd0);
            expect_all("R2 sub", 8'(d), {z, h, c}, 3'b111, 1'b0);
        end
    endtask

    task automatic t_incdec();
        drive(C_INC, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R3 inc wrap", 8'h00, 3'b100, 3'b100, 1'b0);
        drive(C_INC, 8'h00, 8'h41, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R3 inc", 8'h42, 3'b000, 3'b100, 1'b0);
        drive(C_DEC, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R3 dec wrap", 8'hFF, 3'b000, 3'b100, 1'b0);
        drive(C_DEC, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R3 dec zero", 8'h00, 3'b100, 3'b100, 1'b0);
    endtask

    task automatic t_logic();
        drive(C_AND, 8'hF0, 8'h3C, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R4 and", 8'h30, 3'b000, 3'b100, 1'b0);
        drive(C_AND, 8'h0F, 8'hF0, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R4 and zero", 8'h00, 3'b100, 3'b100, 1'b0);
        drive(C_OR, 8'hA0, 8'h05, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R4 or", 8'hA5, 3'b000, 3'b100, 1'b0);
        drive(C_XOR, 8'h5A, 8'h5A, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R4 xor zero", 8'h00, 3'b100, 3'b100, 1'b0);
        drive(C_COM, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R4 com", 8'h00, 3'b100, 3'b100, 1'b0);
        drive(C_CLR, 8'hFF, 8'h77, 8'h00, 1'b0, 1'b1, 3'd0);
        expect_all("R4 clr", 8'h00, 3'b100, 3'b100, 1'b0);
    endtask

    task automatic t_swap();
        drive(C_SWAP, 8'h00, 8'hA5, 8'h00, 1'b0, 1'b1, 3'd0);
        expect_all("R5 swap", 8'h5A, 3'b000, 3'b000, 1'b0);
        drive(C_SWAP, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R5 swap zero", 8'h00, 3'b000, 3'b000, 1'b0);
    endtask

    task automatic t_rotate();
        drive(C_RRC, 8'h00, 8'h81, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R6 rrc", 8'h40, 3'b001, 3'b001, 1'b0);
        drive(C_RRC, 8'h00, 8'h02, 8'h00, 1'b0, 1'b1, 3'd0);
        expect_all("R6 rrc cin", 8'h81, 3'b000, 3'b001, 1'b0);
        drive(C_RLC, 8'h00, 8'h81, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R6 rlc", 8'h02, 3'b001, 3'b001, 1'b0);
        drive(C_RLC, 8'h00, 8'h40, 8'h00, 1'b0, 1'b1, 3'd0);
        expect_all("R6 rlc cin", 8'h81, 3'b000, 3'b001, 1'b0);
    endtask

    task automatic t_skipcnt();
        drive(C_INCSZ, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R7 incsz zero", 8'h00, 3'b000, 3'b000, 1'b1);
        drive(C_INCSZ, 8'h00, 8'h10, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R7 incsz", 8'h11, 3'b000, 3'b000, 1'b0);
        drive(C_DECSZ, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R7 decsz zero", 8'h00, 3'b000, 3'b000, 1'b1);
        drive(C_DECSZ, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0);
        expect_all("R7 decsz wrap", 8'hFF, 3'b000, 3'b000, 1'b0);
    endtask

    task automatic t_bitops();
        for (int b = 0; b < 8; b++) begin
            drive(C_BSET, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'(b));
            expect_all("R8 bset", 8'(1 << b), 3'b000, 3'b000, 1'b0);
            drive(C_BCLR, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 3'(b));
            expect_all("R8 bclr", ~8'(1 << b), 3'b000, 3'b000, 1'b0);
        end
        drive(C_BSET, 8'h00, 8'h10, 8'h00, 1'b0, 1'b0, 3'd4);
        expect_all("R8 bset already", 8'h10, 3'b000, 3'b000, 1'b0);
    endtask

    task automatic t_btest();
        for (int b = 0; b < 8; b++) begin
            logic bitv = (8'hA5 >> b) & 1;
            drive(C_BTSC, 8'h00, 8'hA5, 8'h00, 1'b0, 1'b0, 3'(b));
            expect_all("R9 btsc", 8'hA5, 3'b000, 3'b000, ~bitv);
            drive(C_BTSS, 8'h00, 8'hA5, 8'h00, 1'b0, 1'b0, 3'(b));
            expect_all("R9 btss", 8'hA5, 3'b000, 3'b000, bitv);
        end
    endtask

    task automatic t_imm();
        drive(C_AND, 8'hFF, 8'h0F, 8'hF0, 1'b1, 1'b0, 3'd0);
        expect_all("R11 and imm", 8'hF0, 3'b000, 3'b100, 1'b0);
        drive(C_ADD, 8'h01, 8'h00, 8'hFF, 1'b1, 1'b0, 3'd0);
        expect_all("R11 add imm", 8'h00, 3'b111, 3'b111, 1'b0);
        drive(C_ADD, 8'h01, 8'h00, 8'hFF, 1'b0, 1'b0, 3'd0);
        expect_all("R11 add reg", 8'h01, 3'b000, 3'b111, 1'b0);
    endtask

    task automatic t_unused();
        for (int c = 18; c < 32; c++) begin
            drive(5'(c), 8'h55, 8'h00, 8'h3C, 1'b1, 1'b1, 3'd2);
            expect_all("R12 unused", 8'h3C, 3'b000, 3'b000, 1'b0);
        end
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_incdec();
        t_logic();
        t_swap();
        t_rotate();
        t_skipcnt();
        t_bitops();
        t_btest();
        t_imm();
        t_unused();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule